// File: doc/BRIEF.md
# Programmable Product-Term Array

This block is the logic plane of a versatile programmable logic cell. Twelve dedicated inputs and ten macrocell feedback signals each enter the array on a true and a complement column, 44 columns in all. Every product-term row ANDs the columns whose configuration bit is cleared. Fixed OR gates then sum groups of rows into ten sum outputs. Ten further rows give one output-enable term per output. Two more rows give a global asynchronous-reset term and a global synchronous-preset term.

The connection pattern is held in an on-block configuration store of 132 rows by 44 bits. It is loaded one row per clock through a row-addressed write port. The array outputs are purely combinational functions of the live inputs and the stored pattern. The macrocell registers, polarity selection and pin drivers that consume these terms sit outside the block.

Top module: `pla_array`

## Requirements
- R1: Signal index s covers the inputs (s = 0..11, from `in_i[s]`) and then the feedbacks (s = 12..21, from `fb_i[s-12]`). Column 2s carries the true value of signal s and column 2s+1 its complement. A row's term is the AND of every column whose configuration bit is 0, and a bit of 1 removes that column.
- R2: A row whose 44 configuration bits are all 1 gives a HIGH term, whatever the inputs.
- R3: A row that connects both the true and the complement column of any one signal gives a LOW term, whatever the inputs.
- R4: Sum output k is the OR of a contiguous group of rows. Groups start at row 0 in order of k, with sizes 8, 10, 12, 14, 16, 16, 14, 12, 10, 8 (120 rows).
- R5: Row 120+k drives `oe_o[k]`, row 130 drives `arst_o` and row 131 drives `spre_o`.
- R6: With `cfg_we_i` high at a rising clock edge, `cfg_data_i` is stored into row `cfg_row_i`. The new pattern shows at the outputs right after that edge and not before it.
- R7: A write whose row address is 132 or above changes no stored row.
- R8: While reset is asserted, and after it is released, every stored bit is 1 until it is written. All outputs are therefore HIGH.
- R9: The outputs follow `in_i` and `fb_i` in the same cycle, with no register on the path.
- R10: A write to one row leaves every other row unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the configuration store |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we_i | input | 1 | Row write strobe |
| cfg_row_i | input | 8 | Row address of the write |
| cfg_data_i | input | 44 | Connection bits of the row, 1 = disconnected |
| in_i | input | 12 | Dedicated array inputs |
| fb_i | input | 10 | Macrocell feedback signals |
| sum_o | output | 10 | Sum-of-products result per output |
| oe_o | output | 10 | Output-enable term per output |
| arst_o | output | 1 | Global asynchronous-reset term |
| spre_o | output | 1 | Global synchronous-preset term |

## Verification
A row write and a change of the array inputs can land in the same cycle. In that cycle the outputs must combine the new inputs with the old row pattern, and only after the edge use the new one. The bench provokes this by driving a write and fresh input values on the same falling edge. It checks the outputs once before the next rising edge against the bench model with the old pattern, and once after that edge against the model with the new pattern. Random row loads at mostly-disconnected densities, including addresses past the last row, are mixed with random input vectors. Each vector is checked against a bench function that evaluates the rules column by column.

// File: rtl/pla_pkg.sv
`timescale 1ns/1ps
package pla_pkg;

  // Number of sum rows in group k: sizes rise by tstep up to the middle and fall back.
  function automatic int grp_count(input int k, input int n_out, input int tmin, input int tstep);
    int m;
    m = (k < n_out / 2) ? k : (n_out - 1 - k);
    return tmin + tstep * m;
  endfunction

  // First row of group k.
  function automatic int grp_base(input int k, input int n_out, input int tmin, input int tstep);
    int acc;
    acc = 0;
    for (int j = 0; j < k; j++) acc += grp_count(j, n_out, tmin, tstep);
    return acc;
  endfunction

  // Total number of sum rows.
  function automatic int grp_total(input int n_out, input int tmin, input int tstep);
    return grp_base(n_out, n_out, tmin, tstep);
  endfunction

endpackage

// File: rtl/pla_col_gen.sv
`timescale 1ns/1ps
module pla_col_gen #(
  parameter int N_SIG = 22,
  localparam int N_COL = 2 * N_SIG
) (
  input  logic [N_SIG-1:0] sig_i,
  output logic [N_COL-1:0] col_o
);

  for (genvar s = 0; s < N_SIG; s++) begin : g_sig
    assign col_o[2*s]   = sig_i[s];
    assign col_o[2*s+1] = ~sig_i[s];
  end

endmodule

// File: rtl/pla_cfg_store.sv
`timescale 1ns/1ps
module pla_cfg_store #(
  parameter int N_ROWS = 132,
  parameter int N_COL  = 44,
  parameter int ROW_AW = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [ROW_AW-1:0]            row_i,
  input  logic [N_COL-1:0]             data_i,
  output logic [N_ROWS-1:0][N_COL-1:0] cfg_o
);

  for (genvar r = 0; r < N_ROWS; r++) begin : g_row
    logic             hit;
    logic [N_COL-1:0] row_d;
    logic [N_COL-1:0] row_q;

    assign hit = we_i && (row_i == ROW_AW'(r));

    always_comb begin
      row_d = row_q;
      if (hit) row_d = data_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) row_q <= '1;
      else         row_q <= row_d;
    end

    assign cfg_o[r] = row_q;

    // R6: an addressed write is held in the row after the edge
    assert_row_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && row_i == ROW_AW'(r)) |=> (cfg_o[r] == $past(data_i)));
  end

  // R7: a write past the last row leaves the whole store unchanged
  assert_oob_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && row_i >= ROW_AW'(N_ROWS)) |=> $stable(cfg_o));

endmodule

// File: rtl/pla_and_plane.sv
`timescale 1ns/1ps
module pla_and_plane #(
  parameter int N_ROWS = 132,
  parameter int N_COL  = 44
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [N_ROWS-1:0][N_COL-1:0] cfg_i,
  input  logic [N_COL-1:0]             col_i,
  output logic [N_ROWS-1:0]            term_o
);

  for (genvar r = 0; r < N_ROWS; r++) begin : g_term
    assign term_o[r] = &(col_i | cfg_i[r]);

    // R2: fully disconnected row is HIGH
    assert_open_row_high_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (&cfg_i[r]) |-> term_o[r]);

    // R3: both polarities of signal 0 connected forces LOW
    assert_both_pol_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!cfg_i[r][0] && !cfg_i[r][1]) |-> !term_o[r]);
  end

endmodule

// File: rtl/pla_or_plane.sv
`timescale 1ns/1ps
module pla_or_plane #(
  parameter int N_OUT     = 10,
  parameter int MIN_TERMS = 8,
  parameter int TERM_STEP = 2,
  localparam int N_SUM    = pla_pkg::grp_total(N_OUT, MIN_TERMS, TERM_STEP)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SUM-1:0] term_i,
  output logic [N_OUT-1:0] sum_o
);

  for (genvar k = 0; k < N_OUT; k++) begin : g_grp
    localparam int BASE = pla_pkg::grp_base(k, N_OUT, MIN_TERMS, TERM_STEP);
    localparam int CNT  = pla_pkg::grp_count(k, N_OUT, MIN_TERMS, TERM_STEP);

    assign sum_o[k] = |term_i[BASE +: CNT];

    // R4: a low sum means every row of its own group is low
    assert_group_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sum_o[k] |-> (term_i[BASE +: CNT] == '0));

    // R4: the last row of the group reaches its output
    assert_group_edge_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      term_i[BASE + CNT - 1] |-> sum_o[k]);
  end

endmodule

// File: rtl/pla_array.sv
`timescale 1ns/1ps
module pla_array #(
  parameter int N_IN       = 12,
  parameter int N_MC       = 10,
  parameter int MIN_TERMS  = 8,
  parameter int TERM_STEP  = 2,
  localparam int N_SIG     = N_IN + N_MC,
  localparam int N_COL     = 2 * N_SIG,
  localparam int N_SUM     = pla_pkg::grp_total(N_MC, MIN_TERMS, TERM_STEP),
  localparam int ROW_OE    = N_SUM,
  localparam int ROW_ARST  = N_SUM + N_MC,
  localparam int ROW_SPRE  = N_SUM + N_MC + 1,
  localparam int N_ROWS    = N_SUM + N_MC + 2,
  localparam int ROW_AW    = $clog2(N_ROWS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [ROW_AW-1:0] cfg_row_i,
  input  logic [N_COL-1:0]  cfg_data_i,
  input  logic [N_IN-1:0]   in_i,
  input  logic [N_MC-1:0]   fb_i,
  output logic [N_MC-1:0]   sum_o,
  output logic [N_MC-1:0]   oe_o,
  output logic              arst_o,
  output logic              spre_o
);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  logic [N_SIG-1:0]             sig;
  logic [N_COL-1:0]             col;
  logic [N_ROWS-1:0][N_COL-1:0] cfg;
  logic [N_ROWS-1:0]            term;

  assign sig = {fb_i, in_i};

  pla_col_gen #(.N_SIG(N_SIG)) i_col_gen (
    .sig_i (sig),
    .col_o (col)
  );

  pla_cfg_store #(.N_ROWS(N_ROWS), .N_COL(N_COL), .ROW_AW(ROW_AW)) i_cfg_store (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .we_i   (cfg_we_i),
    .row_i  (cfg_row_i),
    .data_i (cfg_data_i),
    .cfg_o  (cfg)
  );

  pla_and_plane #(.N_ROWS(N_ROWS), .N_COL(N_COL)) i_and_plane (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .cfg_i  (cfg),
    .col_i  (col),
    .term_o (term)
  );

  pla_or_plane #(.N_OUT(N_MC), .MIN_TERMS(MIN_TERMS), .TERM_STEP(TERM_STEP)) i_or_plane (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .term_i (term[N_SUM-1:0]),
    .sum_o  (sum_o)
  );

  assign oe_o   = term[ROW_OE +: N_MC];
  assign arst_o = term[ROW_ARST];
  assign spre_o = term[ROW_SPRE];

  // R8: right after reset release the store is blank, so every output is HIGH
  assert_blank_after_reset_R8: assert property (@(posedge clk_i)
    ($past(rst_sync_q[1]) == 1'b0 && rst_sync_q[1] && !$past(cfg_we_i))
      |-> (&{sum_o, oe_o, arst_o, spre_o}));

endmodule

// File: tb/test_pla_array.sv
`timescale 1ns/1ps
module test_pla_array;

  localparam int NIN  = 12;
  localparam int NMC  = 10;
  localparam int NSIG = 22;
  localparam int NCOL = 44;
  localparam int NROW = 132;
  localparam int CNT[10] = '{8, 10, 12, 14, 16, 16, 14, 12, 10, 8};

  logic            clk_i = 1'b0;
  logic            rst_ni;
  logic            cfg_we_i;
  logic [7:0]      cfg_row_i;
  logic [NCOL-1:0] cfg_data_i;
  logic [NIN-1:0]  in_i;
  logic [NMC-1:0]  fb_i;
  logic [NMC-1:0]  sum_o;
  logic [NMC-1:0]  oe_o;
  logic            arst_o;
  logic            spre_o;

  always #2.5 clk_i = ~clk_i;

  pla_array i_pla_array (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_row_i, .cfg_data_i,
    .in_i, .fb_i, .sum_o, .oe_o, .arst_o, .spre_o
  );

  logic [NCOL-1:0] model [NROW];
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  localparam logic [NCOL-1:0] LOW_ROW = ~44'h3;

  function automatic logic [21:0] expect_out(input logic [NSIG-1:0] s);
    logic [NROW-1:0] t;
    logic [NMC-1:0]  sm;
    int              base;
    for (int r = 0; r < NROW; r++) begin
      t[r] = 1'b1;
      for (int k = 0; k < NSIG; k++) begin
        if (!model[r][2*k]   && !s[k]) t[r] = 1'b0;
        if (!model[r][2*k+1] &&  s[k]) t[r] = 1'b0;
      end
    end
    base = 0;
    for (int k = 0; k < NMC; k++) begin
      sm[k] = 1'b0;
      for (int j = 0; j < CNT[k]; j++) sm[k] = sm[k] | t[base+j];
      base += CNT[k];
    end
    return {t[131], t[130], t[129:120], sm};
  endfunction

  function automatic logic [NCOL-1:0] sparse_row();
    logic [NCOL-1:0] v;
    for (int b = 0; b < NCOL; b++) v[b] = ($urandom % 6) != 0;
    return v;
  endfunction

  task automatic check(input string tag);
    logic [21:0] act, exp;
    #1;
    act = {spre_o, arst_o, oe_o, sum_o};
    exp = expect_out({fb_i, in_i});
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input int row, input logic [NCOL-1:0] d);
    @(negedge clk_i);
    cfg_we_i   = 1'b1;
    cfg_row_i  = 8'(row);
    cfg_data_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    if (row < NROW) model[row] = d;
  endtask

  task automatic set_in(input logic [NIN-1:0] a, input logic [NMC-1:0] b);
    @(negedge clk_i);
    in_i = a;
    fb_i = b;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int base;
    void'($urandom(32'd4242));
    for (int r = 0; r < NROW; r++) model[r] = '1;
    rst_ni = 1'b0; cfg_we_i = 1'b0; cfg_row_i = '0; cfg_data_i = '0;
    in_i = '0; fb_i = '0;
    repeat (3) @(negedge clk_i);
    check("R8 in reset");
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    check("R8 after release");

    // R2: blank rows stay high under varied inputs
    for (int i = 0; i < 4; i++) begin
      set_in(12'($urandom), 10'($urandom));
      check("R2 blank array");
    end

    // R3 / R10: every row made contradictory
    for (int r = 0; r < NROW; r++) wr(r, LOW_ROW);
    for (int i = 0; i < 4; i++) begin
      set_in(12'($urandom), 10'($urandom));
      check("R3 contradiction low");
    end

    // R1: single-column terms, true and complement, input and feedback
    wr(0, ~(44'd1 << 6));
    set_in(12'h008, 10'h0); check("R1 true col high");
    set_in(12'h000, 10'h0); check("R1 true col low");
    wr(0, ~(44'd1 << 7));
    check("R1 complement col");
    set_in(12'h008, 10'h0); check("R1 complement col set");
    wr(0, LOW_ROW);
    wr(8, ~(44'd1 << 28));
    set_in(12'h000, 10'h004); check("R1 feedback true");
    set_in(12'h000, 10'h000); check("R1 feedback low");
    wr(8, LOW_ROW);

    // R4: first and last row of each group reach only their own output
    base = 0;
    for (int k = 0; k < NMC; k++) begin
      wr(base, '1);
      check("R4 group first row");
      wr(base, LOW_ROW);
      wr(base + CNT[k] - 1, '1);
      check("R4 group last row");
      wr(base + CNT[k] - 1, LOW_ROW);
      base += CNT[k];
    end

    // R5 / R10: enable, reset and preset rows
    for (int k = 0; k < NMC; k++) begin
      wr(120 + k, '1);
      check("R5 enable row");
      wr(120 + k, LOW_ROW);
    end
    wr(130, '1); check("R5 reset row");
    wr(131, '1); check("R5 preset row R10");
    wr(130, LOW_ROW); wr(131, LOW_ROW);

    // R7: out-of-range writes
    wr(132, '1); check("R7 row 132 ignored");
    wr(255, '1); check("R7 row 255 ignored");

    // R9 + R6: write and input change in the same cycle
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_row_i = 8'd0; cfg_data_i = ~(44'd1 << 0);
    in_i = 12'h001; fb_i = '0;
    check("R9 new inputs old row");
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    model[0] = ~(44'd1 << 0);
    check("R6 row visible after edge");

    // Random mix
    for (int i = 0; i < 60; i++) begin
      wr($urandom % 140, sparse_row());
      for (int j = 0; j < 5; j++) begin
        set_in(12'($urandom), 10'($urandom));
        check("R1 R4 random");
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule